// File: doc/BRIEF.md
# Debug Access Authentication Gate

This block stands in front of the register port of a debug module and decides which debugger writes may take effect. A debugger reads a 32-bit challenge word, adds one to it and writes the sum back to the same address. A matching answer opens the gate. A wrong answer closes the gate again and draws a fresh challenge. While the gate is closed, every register write is filtered. Only the answer register and the module control word get through. Of the control word, only its module-enable bit (bit 0) may change.

The request port is a single-cycle, DMI-like access: valid, write, address and write data. The response (accept flag and read data) comes back combinationally in the same cycle. Writes that the gate accepts for any other register are signalled on `passWr`, so the debug registers behind the gate can act on them. A strap input selects whether authentication is needed at all. Challenges come from a free-running 32-bit LFSR, so each new challenge differs from the one before it.

Top module: `dbg_auth_gate`

## Requirements
- R1: At reset, `authOk` equals the inverse of `needAuth`, the control word reads 0, and the challenge reads the `SEED` parameter value.
- R2: Reads are always accepted. The answer address (0x30) returns the current challenge. The control address (0x10) returns the control word. The status address (0x11) returns `authOk` in bit 7 with all other bits zero. Every other address reads 0.
- R3: With `needAuth` high, writing challenge + 1 (wrapping modulo 2^32) to address 0x30 sets `authOk` from the next cycle and leaves the challenge unchanged.
- R4: With `needAuth` high, writing any other value to address 0x30 clears `authOk` and loads a challenge different from the previous one.
- R5: With `needAuth` low, writes to address 0x30 change neither the challenge nor `authOk`.
- R6: While `authOk` is low, a write to any address other than 0x30 or 0x10 gets `rspOk` low in the same cycle, keeps `passWr` low, and changes no state.
- R7: While `authOk` is low, a write to address 0x10 that does not raise bit 0 from 0 to 1 changes only bit 0 of the control word.
- R8: A write to 0x10 that raises bit 0 from 0 to 1 resets the module. `authOk` becomes the inverse of `needAuth`, a new challenge is loaded, and the control word becomes 1 if `needAuth` is high or the written word otherwise.
- R9: While `authOk` is high, writes to every address are accepted. Writes to addresses other than 0x30 and 0x10 pulse `passWr`. A write to 0x10 that does not raise bit 0 stores the full word.
- R10: The challenge source never holds zero, and successive challenges drawn by wrong answers each differ from the previous challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| needAuth | input | 1 | Strap: high means authentication is required |
| reqValid | input | 1 | Access request valid |
| reqWrite | input | 1 | High for a write, low for a read |
| reqAddr | input | ADDR_W (7) | Register address |
| reqWdata | input | DATA_W (32) | Write data |
| rspOk | output | 1 | Access accepted (low means rejected write) |
| rspRdata | output | DATA_W (32) | Read data |
| passWr | output | 1 | Accepted write to a register behind the gate |
| moduleActive | output | 1 | Control word bit 0 |
| authOk | output | 1 | Authenticated flag |

## Verification
The hardest case to reach from the ports is an answer whose sum wraps, because the challenge comes from an LFSR that a debugger cannot steer. The bench sets the seed parameter to all ones, so the first challenge after reset is 0xFFFFFFFF and the correct answer is zero. A second hard case is a locked control write that must keep high control bits already set. To reach it, the bench first unlocks the gate and stores a full control word with the enable bit already set. It then relocks the gate with a wrong answer and writes a word with different high bits.

// File: rtl/authgate_pkg.sv
package authgate_pkg;

  typedef struct packed {
    logic setAuth;
    logic failAuth;
    logic modReset;
    logic ctrlFull;
    logic ctrlActOnly;
  } gateStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CHAL = 2'd1,
    RD_CTRL = 2'd2,
    RD_STAT = 2'd3
  } rdSel_t;

endpackage

// File: rtl/authgate_ctrl.sv
module authgate_ctrl
  import authgate_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] AUTH_ADDR = 7'h30,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11
) (
  input  logic              needAuth,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wdataAct,
  input  logic              answerMatch,
  input  logic              authFlag,
  input  logic              activeNow,
  output gateStrobes_t      strobes,
  output rdSel_t            rdSel,
  output logic              rspOk,
  output logic              passWr
);

  logic isAuth, isCtrl, isStat, wrReq, allowed, authWr, ctrlWr, riseAct;

  always_comb begin
    isAuth  = (reqAddr == AUTH_ADDR);
    isCtrl  = (reqAddr == CTRL_ADDR);
    isStat  = (reqAddr == STAT_ADDR);
    wrReq   = reqValid && reqWrite;
    allowed = authFlag || isAuth || isCtrl;
    authWr  = wrReq && isAuth;
    ctrlWr  = wrReq && isCtrl;
    riseAct = ctrlWr && wdataAct && !activeNow;

    strobes.setAuth     = authWr && needAuth && answerMatch;
    strobes.failAuth    = authWr && needAuth && !answerMatch;
    strobes.modReset    = riseAct;
    strobes.ctrlFull    = ctrlWr && !riseAct && authFlag;
    strobes.ctrlActOnly = ctrlWr && !riseAct && !authFlag;

    rspOk  = !(wrReq && !allowed);
    passWr = wrReq && allowed && !isAuth && !isCtrl;

    if (isAuth)      rdSel = RD_CHAL;
    else if (isCtrl) rdSel = RD_CTRL;
    else if (isStat) rdSel = RD_STAT;
    else             rdSel = RD_NONE;
  end

endmodule

// File: rtl/authgate_dp.sv
module authgate_dp
  import authgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SECRET = 32'd1,
  parameter logic [DATA_W-1:0] SEED = 32'h1ACE_B00C,
  parameter logic [DATA_W-1:0] POLY = 32'h8020_0003,
  parameter int STAT_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              needAuth,
  input  gateStrobes_t      strobes,
  input  logic [DATA_W-1:0] wdata,
  input  rdSel_t            rdSel,
  output logic [DATA_W-1:0] rdata,
  output logic              answerMatch,
  output logic              authFlag,
  output logic [DATA_W-1:0] chalVal,
  output logic [DATA_W-1:0] ctrlVal
);

  logic [DATA_W-1:0] lfsr, lfsrNext, expected, statWord;

  always_comb begin
    lfsrNext = {1'b0, lfsr[DATA_W-1:1]} ^ (lfsr[0] ? POLY : '0);
    expected = chalVal + SECRET;
    answerMatch = (wdata == expected);
    statWord = '0;
    statWord[STAT_BIT] = authFlag;
    case (rdSel)
      RD_CHAL: rdata = chalVal;
      RD_CTRL: rdata = ctrlVal;
      RD_STAT: rdata = statWord;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= lfsrNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chalVal <= SEED;
    else if (strobes.modReset || strobes.failAuth) chalVal <= lfsrNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  authFlag <= !needAuth;
    else if (strobes.modReset)   authFlag <= !needAuth;
    else if (strobes.setAuth)    authFlag <= 1'b1;
    else if (strobes.failAuth)   authFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrlVal <= '0;
    else if (strobes.modReset)
      ctrlVal <= needAuth ? {{(DATA_W-1){1'b0}}, 1'b1} : wdata;
    else if (strobes.ctrlFull)
      ctrlVal <= wdata;
    else if (strobes.ctrlActOnly)
      ctrlVal <= {ctrlVal[DATA_W-1:1], wdata[0]};
  end

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R10
  chal_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chalVal != '0);

endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import authgate_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] AUTH_ADDR = 7'h30,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11,
  parameter logic [DATA_W-1:0] SECRET = 32'd1,
  parameter logic [DATA_W-1:0] SEED = 32'h1ACE_B00C,
  parameter logic [DATA_W-1:0] POLY = 32'h8020_0003,
  parameter int STAT_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              needAuth,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspOk,
  output logic [DATA_W-1:0] rspRdata,
  output logic              passWr,
  output logic              moduleActive,
  output logic              authOk
);

  gateStrobes_t      strobes;
  rdSel_t            rdSel;
  logic              answerMatch;
  logic [DATA_W-1:0] chalVal, ctrlVal;

  authgate_ctrl #(
    .ADDR_W(ADDR_W), .AUTH_ADDR(AUTH_ADDR), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) uCtrl (
    .needAuth(needAuth), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .wdataAct(reqWdata[0]), .answerMatch(answerMatch), .authFlag(authOk),
    .activeNow(moduleActive), .strobes(strobes), .rdSel(rdSel),
    .rspOk(rspOk), .passWr(passWr)
  );

  authgate_dp #(
    .DATA_W(DATA_W), .SECRET(SECRET), .SEED(SEED), .POLY(POLY), .STAT_BIT(STAT_BIT)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .needAuth(needAuth), .strobes(strobes), .wdata(reqWdata),
    .rdSel(rdSel), .rdata(rspRdata), .answerMatch(answerMatch), .authFlag(authOk),
    .chalVal(chalVal), .ctrlVal(ctrlVal)
  );

  assign moduleActive = ctrlVal[0];

  logic wrNow, hitAuth, hitCtrl;
  assign wrNow   = reqValid && reqWrite;
  assign hitAuth = (reqAddr == AUTH_ADDR);
  assign hitCtrl = (reqAddr == CTRL_ADDR);

  // R3
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && hitAuth && needAuth && reqWdata == chalVal + SECRET)
      |=> (authOk && $stable(chalVal)));

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && hitAuth && needAuth && reqWdata != chalVal + SECRET)
      |=> (!authOk && chalVal != $past(chalVal)));

  // R5
  no_auth_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && hitAuth && !needAuth) |=> ($stable(chalVal) && $stable(authOk)));

  // R6
  reject_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && !authOk && !hitAuth && !hitCtrl) |-> (!rspOk && !passWr));

  // R6
  reject_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && !authOk && !hitAuth && !hitCtrl)
      |=> ($stable(chalVal) && $stable(authOk) && $stable(ctrlVal)));

  // R7
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && hitCtrl && !authOk && !(reqWdata[0] && !moduleActive))
      |=> (ctrlVal[DATA_W-1:1] == $past(ctrlVal[DATA_W-1:1]) &&
           ctrlVal[0] == $past(reqWdata[0])));

  // R8
  mod_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrNow && hitCtrl && reqWdata[0] && !moduleActive)
      |=> (authOk == !$past(needAuth) && chalVal != $past(chalVal) && moduleActive));

endmodule

// File: tb/tb_dbg_auth_gate.sv
module tb_dbg_auth_gate;

  localparam logic [6:0]  A_AUTH = 7'h30;
  localparam logic [6:0]  A_CTRL = 7'h10;
  localparam logic [6:0]  A_STAT = 7'h11;
  localparam logic [31:0] SEEDV  = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        needAuth = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [6:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspOk, passWr, moduleActive, authOk;
  logic [31:0] rspRdata;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  dbg_auth_gate #(.SEED(SEEDV)) dut (
    .clk(clk), .rst_n(rst_n), .needAuth(needAuth), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .rspOk(rspOk),
    .rspRdata(rspRdata), .passWr(passWr), .moduleActive(moduleActive), .authOk(authOk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [6:0] a, input logic [31:0] d,
                     output logic ok, output logic [31:0] rd, output logic pw);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    #1;
    ok = rspOk; rd = rspRdata; pw = passWr;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd32(input logic [6:0] a, output logic [31:0] v);
    logic ok, pw;
    acc(1'b0, a, '0, ok, v, pw);
  endtask

  task automatic doReset(input logic na);
    @(negedge clk);
    rst_n = 1'b0; needAuth = na;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] a, input logic [31:0] c,
                                          input logic [31:0] ctl, input logic au);
    if (a == A_AUTH) return c;
    if (a == A_CTRL) return ctl;
    if (a == A_STAT) return {24'd0, au, 7'd0};
    return 32'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic ok, pw;
    logic [31:0] v, c, c2;

    // Phase A: authentication required
    doReset(1'b1);
    #1;
    chk("R1 authOk after reset", {31'd0, authOk}, 32'd0);
    rd32(A_AUTH, v); chk("R1 challenge after reset", v, SEEDV);
    rd32(A_CTRL, v); chk("R1 ctrl after reset", v, 32'd0);

    // R2 read sweep while locked
    for (int a = 0; a < 128; a++) begin
      acc(1'b0, a[6:0], '0, ok, v, pw);
      chk("R2 read ok", {31'd0, ok}, 32'd1);
      chk("R2 read data", v, expRead(a[6:0], SEEDV, 32'd0, 1'b0));
    end

    // R6 locked write sweep
    for (int a = 0; a < 128; a++) begin
      if (a[6:0] != A_AUTH && a[6:0] != A_CTRL) begin
        acc(1'b1, a[6:0], 32'hDEAD_0001 | a, ok, v, pw);
        chk("R6 reject rspOk", {31'd0, ok}, 32'd0);
        chk("R6 reject passWr", {31'd0, pw}, 32'd0);
      end
    end
    rd32(A_AUTH, v); chk("R6 challenge untouched", v, SEEDV);
    rd32(A_CTRL, v); chk("R6 ctrl untouched", v, 32'd0);
    chk("R6 still locked", {31'd0, authOk}, 32'd0);

    // R3 wrapping answer: 0xFFFFFFFF + 1 = 0
    acc(1'b1, A_AUTH, 32'd0, ok, v, pw);
    chk("R3 answer accepted", {31'd0, ok}, 32'd1);
    chk("R3 unlocked", {31'd0, authOk}, 32'd1);
    rd32(A_STAT, v); chk("R2 status bit7", v, 32'h80);
    rd32(A_AUTH, v); chk("R3 challenge kept", v, SEEDV);

    // R9 authenticated write sweep
    for (int a = 0; a < 128; a++) begin
      if (a[6:0] != A_AUTH && a[6:0] != A_CTRL) begin
        acc(1'b1, a[6:0], 32'h5555_0000 | a, ok, v, pw);
        chk("R9 accept rspOk", {31'd0, ok}, 32'd1);
        chk("R9 passWr pulse", {31'd0, pw}, 32'd1);
      end
    end
    acc(1'b1, A_CTRL, 32'h1234_0000, ok, v, pw);
    chk("R9 ctrl write ok", {31'd0, ok}, 32'd1);
    chk("R9 ctrl no passWr", {31'd0, pw}, 32'd0);
    rd32(A_CTRL, v); chk("R9 ctrl full write", v, 32'h1234_0000);

    // R4 wrong answer relocks
    rd32(A_AUTH, c);
    acc(1'b1, A_AUTH, c + 32'd2, ok, v, pw);
    chk("R4 wrong answer ok", {31'd0, ok}, 32'd1);
    chk("R4 relocked", {31'd0, authOk}, 32'd0);
    rd32(A_AUTH, c2); chk("R4 new challenge differs", {31'd0, c2 != c}, 32'd1);

    // R7 locked ctrl write, no rise
    acc(1'b1, A_CTRL, 32'hFFFF_0000, ok, v, pw);
    chk("R7 ctrl write ok", {31'd0, ok}, 32'd1);
    rd32(A_CTRL, v); chk("R7 only bit0 changes", v, 32'h1234_0000);

    // R8 rise of bit 0 while locked
    rd32(A_AUTH, c);
    acc(1'b1, A_CTRL, 32'hABCD_0001, ok, v, pw);
    rd32(A_CTRL, v); chk("R8 ctrl after module reset", v, 32'd1);
    chk("R8 moduleActive", {31'd0, moduleActive}, 32'd1);
    chk("R8 locked after module reset", {31'd0, authOk}, 32'd0);
    rd32(A_AUTH, c2); chk("R8 new challenge", {31'd0, c2 != c}, 32'd1);

    // R7 with high bits set: unlock, store full word with bit0 set, relock
    acc(1'b1, A_AUTH, c2 + 32'd1, ok, v, pw);
    chk("R3 unlock again", {31'd0, authOk}, 32'd1);
    acc(1'b1, A_CTRL, 32'h5678_0001, ok, v, pw);
    rd32(A_CTRL, v); chk("R9 ctrl full word", v, 32'h5678_0001);
    rd32(A_AUTH, c);
    acc(1'b1, A_AUTH, c + 32'd7, ok, v, pw);
    chk("R4 relock", {31'd0, authOk}, 32'd0);
    acc(1'b1, A_CTRL, 32'hFFFF_0000, ok, v, pw);
    rd32(A_CTRL, v); chk("R7 keeps high bits", v, 32'h5678_0000);
    acc(1'b1, A_CTRL, 32'h0000_0000, ok, v, pw);
    rd32(A_CTRL, v); chk("R7 clear stays", v, 32'h5678_0000);

    // R10 / R4 chain of wrong answers, R3 unlocks with varied challenges
    for (int k = 0; k < 16; k++) begin
      rd32(A_AUTH, c);
      acc(1'b1, A_AUTH, c + 32'd2 + k, ok, v, pw);
      chk("R4 chain locked", {31'd0, authOk}, 32'd0);
      rd32(A_AUTH, c2);
      chk("R10 successive challenge differs", {31'd0, c2 != c}, 32'd1);
      chk("R10 challenge nonzero", {31'd0, c2 != 0}, 32'd1);
      if (k % 2 == 0) begin
        acc(1'b1, A_AUTH, c2 + 32'd1, ok, v, pw);
        chk("R3 varied unlock", {31'd0, authOk}, 32'd1);
      end
    end

    // Phase B: authentication not required
    doReset(1'b0);
    #1;
    chk("R1 authOk when not needed", {31'd0, authOk}, 32'd1);
    rd32(A_AUTH, v); chk("R1 challenge seed B", v, SEEDV);
    acc(1'b1, A_AUTH, 32'h0000_1234, ok, v, pw);
    chk("R5 auth write ok", {31'd0, ok}, 32'd1);
    chk("R5 authOk unchanged", {31'd0, authOk}, 32'd1);
    rd32(A_AUTH, v); chk("R5 challenge unchanged", v, SEEDV);
    acc(1'b1, A_AUTH, 32'd0, ok, v, pw);
    rd32(A_AUTH, v); chk("R5 challenge unchanged 2", v, SEEDV);
    rd32(A_STAT, v); chk("R2 status open", v, 32'h80);

    acc(1'b1, A_CTRL, 32'h9ABC_0001, ok, v, pw);
    rd32(A_CTRL, v); chk("R8 ctrl takes word when open", v, 32'h9ABC_0001);
    chk("R8 authOk stays", {31'd0, authOk}, 32'd1);
    rd32(A_AUTH, v); chk("R8 challenge reloaded", {31'd0, v != SEEDV}, 32'd1);

    for (int a = 0; a < 128; a++) begin
      if (a[6:0] != A_AUTH && a[6:0] != A_CTRL) begin
        acc(1'b1, a[6:0], 32'hA5A5_0000 | a, ok, v, pw);
        chk("R9 open sweep ok", {31'd0, ok}, 32'd1);
        chk("R9 open sweep passWr", {31'd0, pw}, 32'd1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule